// File: doc/BRIEF.md
# Sliding-Window Byte Stream Decompressor

This block expands a stream compressed with a sliding-window (back-reference) scheme into a destination memory. The compressed bytes arrive on a valid/ready byte port. After a start pulse the block reads a 4-byte header that gives the output size. It then alternates between flag bytes and tokens. A token is either a literal byte or a two-byte back-reference that copies earlier output. Decoded bytes go out on a synchronous write port. Back-references are resolved by reading that same destination memory through a read port that returns data one cycle after the request.

A mode input selects one of two write styles. Byte mode writes each output byte on its own. Halfword mode is for memories that take only 16-bit writes. It pairs an even-address byte with the following odd-address byte and writes them together. When a copy needs the held even byte before it has been written, the block supplies it from its own latch. When decoding ends, a one-cycle done pulse is raised. The final source and destination pointers are then held on the outputs.

Top module: `lz_stream_unpack`

## Requirements
- R1: The first four stream bytes form a little-endian header. Bits 31:8 give the output length in bytes and bits 7:0 are ignored. A length of zero ends decoding right after the header, with no write and no further byte accepted.
- R2: A flag byte controls the next eight tokens, taken from bit 7 down to bit 0. A new flag byte is accepted only after eight tokens, and only while output length remains.
- R3: A flag bit of 0 means the next stream byte is a literal that is written to the current destination address, which then advances by one.
- R4: A flag bit of 1 means two stream bytes B0 then B1. The displacement is {B0[3:0], B1}, the copy starts at destination minus displacement minus 1, and the copy length is B0[7:4] + 3 (3 to 18 bytes).
- R5: A back-reference copies one byte at a time, each read seeing every earlier write, so an overlapping source repeats the bytes just produced.
- R6: The remaining-length count drops by one per output byte but stops at zero. A back-reference always copies its full length, even past the header length. Decoding ends after the token during which the count reaches zero, even in the middle of a flag group.
- R7: In byte mode (half_mode = 0) every output byte is one write with wr_wide = 0, the byte on wr_data[7:0], at its own address.
- R8: In halfword mode (half_mode = 1) every write has wr_wide = 1 and an even wr_addr. It carries the even byte in wr_data[7:0] and the following odd byte in wr_data[15:8]. A final unpaired even byte is never written. dst_base must be even in this mode.
- R9: Reads request the even-aligned halfword (rd_addr[0] = 0), and rd_data[15:8] holds the odd byte. The byte is chosen by bit 0 of the copy address. In halfword mode a read of the held, not-yet-written byte takes the latched value.
- R10: done pulses high for exactly one cycle. src_end is then src_base plus the number of stream bytes consumed, header included, and dst_end is the address just past the last byte copied.
- R11: While idle, in_ready stays low and no read or write is issued. Stream bytes offered then are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decode (taken when idle) |
| half_mode | input | 1 | 1 = halfword-only writes, 0 = byte writes; hold during a decode |
| src_base | input | AW | Start value of the source pointer |
| dst_base | input | AW | First destination byte address |
| in_valid | input | 1 | Stream byte available |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block accepts the stream byte |
| rd_en | output | 1 | Read request to destination memory |
| rd_addr | output | AW | Even-aligned read address |
| rd_data | input | 16 | Halfword returned the cycle after rd_en |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | AW | Write address |
| wr_wide | output | 1 | 1 = 16-bit write, 0 = byte write |
| wr_data | output | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | One-cycle completion pulse |
| src_end | output | AW | Final source pointer |
| dst_end | output | AW | Final destination pointer |

## Verification
The bench builds the block with AW = 12, so a 4 KiB byte array covers the whole destination space and the whole 12-bit displacement field. It sweeps all sixteen length codes at displacements 0 to 2 in both modes. Those runs reach the overlapping-copy case and the latch forwarding of halfword mode. Seeded token streams then cross many flag groups, with and without input gaps, and some cut the header length short inside the last back-reference.

// File: rtl/lz_unpack_pkg.sv
package lz_unpack_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_FLAG,
    S_TOK,
    S_REF2,
    S_CRD,
    S_CWR,
    S_DONE
  } lz_state_e;

  localparam int unsigned LEN_W     = 24;  // header length field width
  localparam int unsigned TOK_GROUP = 8;   // tokens per flag byte
  localparam int unsigned MIN_MATCH = 3;   // length bias of a back-reference
  localparam int unsigned DISP_W    = 12;  // displacement field width

endpackage

// File: rtl/lz_out_pack.sv
// Output formation: narrow byte writes or paired halfword writes with an
// even-byte holding latch that is forwarded to back-reference reads.
module lz_out_pack #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          half_mode,
  input  logic          emit_vld,
  input  logic [7:0]    emit_byte,
  input  logic [AW-1:0] dst_addr,
  input  logic [AW-1:0] src_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_wide,
  output logic [15:0]   wr_data,
  output logic          fwd_hit,
  output logic [7:0]    fwd_byte
);

  logic [7:0] lat_q, lat_d;
  logic       pend_q, pend_d;
  logic       lat_en;
  logic [AW-1:0] dst_even;

  assign dst_even = {dst_addr[AW-1:1], 1'b0};
  assign lat_en   = emit_vld & half_mode & ~dst_addr[0];

  always_comb begin
    lat_d  = lat_q;
    pend_d = pend_q;
    if (clear) begin
      pend_d = 1'b0;
    end else if (emit_vld && half_mode) begin
      if (lat_en) begin
        lat_d  = emit_byte;
        pend_d = 1'b1;
      end else begin
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  assign wr_en    = emit_vld & (~half_mode | dst_addr[0]);
  assign wr_wide  = half_mode;
  assign wr_addr  = half_mode ? dst_even : dst_addr;
  assign wr_data  = half_mode ? {emit_byte, lat_q} : {8'h00, emit_byte};
  assign fwd_hit  = half_mode & pend_q & dst_addr[0] & (src_addr == dst_even);
  assign fwd_byte = lat_q;

  p_half_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && half_mode) |-> (wr_wide && !wr_addr[0]));

  p_pair_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && half_mode) |-> pend_q);

  p_byte_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !half_mode) |-> !wr_wide);

endmodule

// File: rtl/lz_unpack_ctrl.sv
// Stream parser and copy sequencer: header, flag groups, literals,
// back-references, remaining-length bookkeeping and pointer tracking.
module lz_unpack_ctrl
  import lz_unpack_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  input  logic          fwd_hit,
  input  logic [7:0]    fwd_byte,
  output logic          emit_vld,
  output logic [7:0]    emit_byte,
  output logic [AW-1:0] dst_addr,
  output logic [AW-1:0] cpy_addr,
  output logic          done,
  output logic [AW-1:0] src_end,
  output logic [AW-1:0] dst_end
);

  localparam int unsigned TCW = $clog2(TOK_GROUP + 1);
  localparam int unsigned CLW = 5;

  lz_state_e        st_q, st_d;
  logic [AW-1:0]    src_q, src_d, dst_q, dst_d, cps_q, cps_d;
  logic [LEN_W-1:0] rem_q, rem_d, rem_dec;
  logic [7:0]       flg_q, flg_d, hi_q, hi_d;
  logic [TCW-1:0]   tcnt_q, tcnt_d;
  logic [1:0]       hidx_q, hidx_d;
  logic [CLW-1:0]   cleft_q, cleft_d;
  logic             fire, hdr_zero;
  logic [DISP_W-1:0] disp;
  logic [7:0]       cp_byte;

  assign in_ready = (st_q == S_HDR) || (st_q == S_FLAG) ||
                    (st_q == S_TOK) || (st_q == S_REF2);
  assign fire     = in_valid & in_ready;
  assign rem_dec  = (rem_q != '0) ? rem_q - 1'b1 : '0;
  assign hdr_zero = (in_data == 8'h00) && (rem_q[15:0] == 16'h0000);
  assign disp     = {hi_q[3:0], in_data};
  assign cp_byte  = fwd_hit ? fwd_byte : (cps_q[0] ? rd_data[15:8] : rd_data[7:0]);

  always_comb begin
    st_d    = st_q;
    src_d   = src_q;
    dst_d   = dst_q;
    cps_d   = cps_q;
    rem_d   = rem_q;
    flg_d   = flg_q;
    hi_d    = hi_q;
    tcnt_d  = tcnt_q;
    hidx_d  = hidx_q;
    cleft_d = cleft_q;
    unique case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d   = S_HDR;
          src_d  = src_base;
          dst_d  = dst_base;
          hidx_d = '0;
          rem_d  = '0;
        end
      end
      S_HDR: begin
        if (fire) begin
          src_d  = src_q + 1'b1;
          hidx_d = hidx_q + 1'b1;
          case (hidx_q)
            2'd1:    rem_d[7:0]   = in_data;
            2'd2:    rem_d[15:8]  = in_data;
            2'd3:    rem_d[23:16] = in_data;
            default: ;
          endcase
          if (hidx_q == 2'd3) begin
            st_d = hdr_zero ? S_DONE : S_FLAG;
          end
        end
      end
      S_FLAG: begin
        if (fire) begin
          src_d  = src_q + 1'b1;
          flg_d  = in_data;
          tcnt_d = TCW'(TOK_GROUP);
          st_d   = S_TOK;
        end
      end
      S_TOK: begin
        if (fire) begin
          src_d = src_q + 1'b1;
          if (!flg_q[7]) begin
            dst_d  = dst_q + 1'b1;
            rem_d  = rem_dec;
            flg_d  = {flg_q[6:0], 1'b0};
            tcnt_d = tcnt_q - 1'b1;
            if (rem_dec == '0)               st_d = S_DONE;
            else if (tcnt_q == TCW'(1))      st_d = S_FLAG;
            else                             st_d = S_TOK;
          end else begin
            hi_d = in_data;
            st_d = S_REF2;
          end
        end
      end
      S_REF2: begin
        if (fire) begin
          src_d   = src_q + 1'b1;
          cps_d   = dst_q - AW'(disp) - AW'(1);
          cleft_d = {1'b0, hi_q[7:4]} + CLW'(MIN_MATCH);
          flg_d   = {flg_q[6:0], 1'b0};
          tcnt_d  = tcnt_q - 1'b1;
          st_d    = S_CRD;
        end
      end
      S_CRD: begin
        st_d = S_CWR;
      end
      S_CWR: begin
        dst_d   = dst_q + 1'b1;
        cps_d   = cps_q + 1'b1;
        cleft_d = cleft_q - 1'b1;
        rem_d   = rem_dec;
        if (cleft_q == CLW'(1)) begin
          if (rem_dec == '0)          st_d = S_DONE;
          else if (tcnt_q == '0)      st_d = S_FLAG;
          else                        st_d = S_TOK;
        end else begin
          st_d = S_CRD;
        end
      end
      S_DONE: begin
        st_d = S_IDLE;
      end
      default: begin
        st_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cps_q   <= '0;
      rem_q   <= '0;
      flg_q   <= '0;
      hi_q    <= '0;
      tcnt_q  <= '0;
      hidx_q  <= '0;
      cleft_q <= '0;
    end else begin
      st_q    <= st_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      cps_q   <= cps_d;
      rem_q   <= rem_d;
      flg_q   <= flg_d;
      hi_q    <= hi_d;
      tcnt_q  <= tcnt_d;
      hidx_q  <= hidx_d;
      cleft_q <= cleft_d;
    end
  end

  assign rd_en     = (st_q == S_CRD);
  assign rd_addr   = {cps_q[AW-1:1], 1'b0};
  assign emit_vld  = ((st_q == S_TOK) && fire && !flg_q[7]) || (st_q == S_CWR);
  assign emit_byte = (st_q == S_CWR) ? cp_byte : in_data;
  assign dst_addr  = dst_q;
  assign cpy_addr  = cps_q;
  assign done      = (st_q == S_DONE);
  assign src_end   = src_q;
  assign dst_end   = dst_q;

  p_src_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (src_q == $past(src_q) + 1'b1));

  p_flag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FLAG && fire) |=> (st_q == S_TOK && tcnt_q == TCW'(TOK_GROUP)));

  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_REF2 && fire) |=> (cleft_q >= CLW'(3) && cleft_q <= CLW'(18)));

  p_copy_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CWR) |=> (dst_q == $past(dst_q) + 1'b1));

  p_rem_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CWR && rem_q == '0) |=> (rem_q == '0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE) |-> (!emit_vld && !rd_en && !in_ready));

endmodule

// File: rtl/lz_stream_unpack.sv
module lz_stream_unpack #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          half_mode,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [15:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_wide,
  output logic [15:0]   wr_data,
  output logic          done,
  output logic [AW-1:0] src_end,
  output logic [AW-1:0] dst_end
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          emit_vld, fwd_hit;
  logic [7:0]    emit_byte, fwd_byte;
  logic [AW-1:0] dst_addr, cpy_addr;
  logic          start_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];
  assign start_ok  = start & rst_int_n;

  lz_unpack_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start_ok),
    .src_base  (src_base),
    .dst_base  (dst_base),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .fwd_hit   (fwd_hit),
    .fwd_byte  (fwd_byte),
    .emit_vld  (emit_vld),
    .emit_byte (emit_byte),
    .dst_addr  (dst_addr),
    .cpy_addr  (cpy_addr),
    .done      (done),
    .src_end   (src_end),
    .dst_end   (dst_end)
  );

  lz_out_pack #(.AW(AW)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (start_ok),
    .half_mode (half_mode),
    .emit_vld  (emit_vld),
    .emit_byte (emit_byte),
    .dst_addr  (dst_addr),
    .src_addr  (cpy_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_wide   (wr_wide),
    .wr_data   (wr_data),
    .fwd_hit   (fwd_hit),
    .fwd_byte  (fwd_byte)
  );

  p_read_aligned_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en |-> !rd_addr[0]);

  p_no_rw_overlap_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_en |-> !wr_en);

endmodule

// File: tb/test_lz_stream_unpack.sv
module test_lz_stream_unpack;

  localparam int AW  = 12;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          half_mode = 1'b0;
  logic [AW-1:0] src_base = '0;
  logic [AW-1:0] dst_base = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data = 16'h0000;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic          wr_wide;
  logic [15:0]   wr_data;
  logic          done;
  logic [AW-1:0] src_end;
  logic [AW-1:0] dst_end;

  lz_stream_unpack #(.AW(AW)) i_lz_stream_unpack (
    .clk(clk), .rst_n(rst_n), .start(start), .half_mode(half_mode),
    .src_base(src_base), .dst_base(dst_base),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_wide(wr_wide), .wr_data(wr_data),
    .done(done), .src_end(src_end), .dst_end(dst_end)
  );

  always #4 clk = ~clk;  // 125 MHz

  logic [7:0] mem      [MEM];
  logic [7:0] init_mem [MEM];
  logic [7:0] exp_mem  [MEM];
  logic [7:0] stream   [4096];
  int slen = 0;
  int sidx = 0;
  int cyc = 0;
  int wr_count = 0;
  int bad_wr = 0;
  int bad_rd = 0;
  logic feed = 1'b0;
  logic gaps = 1'b0;
  logic feed_rst = 1'b0;
  logic do_load = 1'b0;
  int n_chk = 0;
  int n_fail = 0;
  int unsigned rng = 32'h1234_5678;
  bit finished = 1'b0;

  function automatic int unsigned rnd();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  // stream source, driven away from the active edge
  always @(negedge clk) begin
    in_valid = feed && (sidx < slen) && (!gaps || (cyc % 4 >= 2));
    in_data  = stream[sidx % 4096];
  end

  // destination memory and port observers
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (feed_rst) sidx <= 0;
    else if (in_valid && in_ready) sidx <= sidx + 1;
    if (do_load) begin
      for (int i = 0; i < MEM; i++) mem[i] = init_mem[i];
    end else if (wr_en) begin
      wr_count <= wr_count + 1;
      if (half_mode && (!wr_wide || wr_addr[0])) bad_wr <= bad_wr + 1;
      if (!half_mode && wr_wide) bad_wr <= bad_wr + 1;
      mem[wr_addr] = wr_data[7:0];
      if (wr_wide) mem[wr_addr + 1'b1] = wr_data[15:8];
    end
    if (rd_en) begin
      rd_data <= {mem[{rd_addr[AW-1:1], 1'b1}], mem[{rd_addr[AW-1:1], 1'b0}]};
      if (rd_addr[0]) bad_rd <= bad_rd + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // behavioural reference built from the requirements
  task automatic ref_decode(input bit hm, input int dbase, input int sbase,
                            output int es, output int ed);
    int len, p, d, s, n, dsp;
    logic [7:0] fl, b0, b1;
    for (int i = 0; i < MEM; i++) exp_mem[i] = init_mem[i];
    len = int'(stream[1]) | (int'(stream[2]) << 8) | (int'(stream[3]) << 16);
    p = 4;
    d = dbase;
    while (len > 0) begin
      fl = stream[p];
      p++;
      for (int t = 0; t < 8 && len > 0; t++) begin
        if (!fl[7-t]) begin
          exp_mem[d & (MEM-1)] = stream[p];
          p++; d++; len--;
        end else begin
          b0 = stream[p]; b1 = stream[p+1]; p += 2;
          dsp = int'({b0[3:0], b1});
          n = int'(b0[7:4]) + 3;
          s = d - dsp - 1;
          for (int k = 0; k < n; k++) begin
            exp_mem[d & (MEM-1)] = exp_mem[s & (MEM-1)];
            s++; d++;
            if (len > 0) len--;
          end
        end
      end
    end
    if (hm && d[0]) exp_mem[(d-1) & (MEM-1)] = init_mem[(d-1) & (MEM-1)];
    es = (sbase + p) & (MEM-1);
    ed = d & (MEM-1);
  endtask

  task automatic set_header(input int len);
    stream[0] = 8'(rnd());
    stream[1] = 8'(len);
    stream[2] = 8'(len >> 8);
    stream[3] = 8'(len >> 16);
  endtask

  task automatic gen_random(input int ntok, input int lit_pct, input int max_disp, input bit trunc);
    int pos, prod, fpos, lastl, m, dsp, lc, len;
    bit isref;
    pos = 4; prod = 0; fpos = 4; lastl = 0;
    for (int t = 0; t < ntok; t++) begin
      if (t % 8 == 0) begin
        fpos = pos;
        stream[pos] = 8'h00;
        pos++;
      end
      isref = (t != 0) && ((int'(rnd() % 100) >= lit_pct) || (trunc && t == ntok-1));
      if (isref) begin
        stream[fpos][7-(t%8)] = 1'b1;
        m = (prod < max_disp + 1) ? prod : max_disp + 1;
        dsp = int'(rnd() % unsigned'(m));
        lc = int'(rnd() % 16);
        stream[pos]   = {lc[3:0], dsp[11:8]};
        stream[pos+1] = dsp[7:0];
        pos += 2;
        prod += lc + 3;
        lastl = lc + 3;
      end else begin
        stream[pos] = 8'(rnd());
        pos++;
        prod++;
        lastl = 0;
      end
    end
    len = (trunc && lastl > 0) ? prod - (lastl - 1) : prod;
    set_header(len);
    slen = pos;
  endtask

  task automatic run_case(input string tag, input bit hm, input int dbase,
                          input int sbase, input bit gp);
    int es, ed, wc0, bw0, br0, steps, nbad, first;
    for (int i = 0; i < MEM; i++) init_mem[i] = 8'(rnd());
    @(negedge clk); do_load = 1'b1;
    @(negedge clk); do_load = 1'b0;
    ref_decode(hm, dbase, sbase, es, ed);
    half_mode = hm;
    src_base  = AW'(sbase);
    dst_base  = AW'(dbase);
    gaps      = gp;
    feed_rst  = 1'b1;
    @(negedge clk); feed_rst = 1'b0; feed = 1'b1;
    wc0 = wr_count; bw0 = bad_wr; br0 = bad_rd;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    steps = 0;
    while (!done && steps < 20000) begin
      @(negedge clk);
      steps++;
    end
    check(done == 1'b1, {tag, " R10 done seen"}, int'(done), 1);
    check(src_end == AW'(es), {tag, " R10 src_end"}, int'(src_end), es);
    check(dst_end == AW'(ed), {tag, " R10 R6 dst_end"}, int'(dst_end), ed);
    check(sidx == es - sbase || sidx == es - sbase + MEM, {tag, " R2 bytes consumed"},
          sidx, es - sbase);
    @(negedge clk);
    check(done == 1'b0, {tag, " R10 single-cycle done"}, int'(done), 0);
    feed = 1'b0;
    nbad = 0; first = -1;
    for (int i = 0; i < MEM; i++) begin
      if (mem[i] !== exp_mem[i]) begin
        if (first < 0) first = i;
        nbad++;
      end
    end
    check(nbad == 0, {tag, " R3 R4 R5 memory image (count, first addr in next line if any)"},
          nbad, 0);
    if (nbad != 0) check(1'b0, {tag, " R5 first bad byte"}, int'(mem[first]), int'(exp_mem[first]));
    if (hm) begin
      check(bad_wr == bw0, {tag, " R8 non-wide or odd writes"}, bad_wr - bw0, 0);
      check(bad_rd == br0, {tag, " R9 unaligned reads"}, bad_rd - br0, 0);
    end else begin
      check(bad_wr == bw0, {tag, " R7 wide writes in byte mode"}, bad_wr - bw0, 0);
    end
    if (ed == dbase) check(wr_count == wc0, {tag, " R1 no writes"}, wr_count - wc0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int wc0;
    bit saw_ready;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    check(done == 1'b0, "R10 reset done", int'(done), 0);
    check(in_ready == 1'b0, "R11 reset in_ready", int'(in_ready), 0);
    check(wr_en == 1'b0 && rd_en == 1'b0, "R11 reset no access", int'({wr_en, rd_en}), 0);

    // idle: offered bytes are not taken
    stream[0] = 8'h55; stream[1] = 8'h66; stream[2] = 8'h77; slen = 3;
    feed = 1'b1; gaps = 1'b0; wc0 = wr_count; saw_ready = 1'b0;
    repeat (10) begin
      @(negedge clk);
      if (in_ready) saw_ready = 1'b1;
    end
    feed = 1'b0;
    check(!saw_ready, "R11 in_ready while idle", int'(saw_ready), 0);
    check(sidx == 0, "R11 bytes consumed while idle", sidx, 0);
    check(wr_count == wc0, "R11 writes while idle", wr_count - wc0, 0);

    // zero length header with trailing bytes
    set_header(0); stream[4] = 8'hAA; stream[5] = 8'hBB; slen = 6;
    run_case("zero-len R1", 1'b0, 12'h100, 12'h3A0, 1'b0);

    // all literals over three flag groups
    gen_random(20, 100, 0, 1'b0);
    run_case("literals R3", 1'b0, 12'h200, 12'h010, 1'b0);
    gen_random(20, 100, 0, 1'b0);
    run_case("literals-half R8", 1'b1, 12'h240, 12'h011, 1'b1);

    // run: one literal then overlapping copy of displacement 0
    set_header(19);
    stream[4] = 8'h40; stream[5] = 8'h41; stream[6] = 8'hF0; stream[7] = 8'h00; slen = 8;
    run_case("run-byte R5", 1'b0, 12'h300, 12'h020, 1'b0);
    run_case("run-half R9", 1'b1, 12'h300, 12'h020, 1'b0);

    // header length ends inside a back-reference
    set_header(5);
    stream[4] = 8'h20; stream[5] = 8'h78; stream[6] = 8'h79;
    stream[7] = 8'hF0; stream[8] = 8'h01; slen = 9;
    run_case("trunc-byte R6", 1'b0, 12'h400, 12'h030, 1'b0);
    run_case("trunc-half R6", 1'b1, 12'h400, 12'h030, 1'b1);

    // odd-length output in halfword mode leaves its last byte unwritten
    set_header(5);
    stream[4] = 8'h00;
    for (int i = 5; i < 10; i++) stream[i] = 8'(rnd());
    slen = 10;
    run_case("odd-half R8", 1'b1, 12'h480, 12'h040, 1'b0);
    check(mem[12'h484] === init_mem[12'h484], "R8 trailing byte untouched",
          int'(mem[12'h484]), int'(init_mem[12'h484]));

    // every length code, small displacements, alternating modes
    for (int lc = 0; lc < 16; lc++) begin
      set_header(3 + lc + 3);
      stream[4] = 8'h10;
      stream[5] = 8'(rnd()); stream[6] = 8'(rnd()); stream[7] = 8'(rnd());
      stream[8] = {4'(lc), 4'h0};
      stream[9] = 8'(lc % 3);
      slen = 10;
      run_case("len-sweep R4", lc[0], 12'h500 + lc * 32, 12'h050, lc[1]);
    end

    // seeded token streams, both modes, with and without gaps and cut-off
    for (int sd = 0; sd < 16; sd++) begin
      gen_random(30, 50, 600, sd[1]);
      run_case("random R2", sd[0], 12'h800, 12'h100 + sd, sd[2]);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule